// File: doc/BRIEF.md
# Differential Pairwise Response Extractor

This block turns a bank of averaged oscillation counts into a device identifier. One 8-bit mean arrives per accepted cycle on a valid-qualified stream. Each value after the first is subtracted from its predecessor, giving 63 differences for a 64-value run. Only the top bits of each difference are stable between repeated measurements, so only they are kept. A run-time width code selects 2, 3 or 4 top bits per difference. The kept groups are packed into an identifier of 126, 189 or 252 bits, with difference 0 in the least significant positions.

A run is exactly 64 accepted means. The identifier is registered and flagged with a one-cycle valid pulse at the end of each run. It stays on the output until the next run completes. The width code is captured together with the first mean of a run, so software may change it at any time without corrupting a run in flight.

Top module: `pair_diff_id_builder`

## Requirements
- R1: After reset `id_valid` is 0 and `id_word` is all zeros.
- R2: Difference k equals mean k+1 minus mean k, taken modulo 256, so a falling pair wraps (for example 0x10 followed by 0x05 gives 0xF5).
- R3: With `width_code` = 0, bits 7:6 of difference k appear at `id_word` bits 2k+1:2k, and bits 251:126 are zero.
- R4: With `width_code` = 1, bits 7:5 of difference k appear at `id_word` bits 3k+2:3k, and bits 251:189 are zero.
- R5: With `width_code` = 2 or 3, bits 7:4 of difference k appear at `id_word` bits 4k+3:4k.
- R6: Bits 3:0 of every difference have no effect on `id_word`.
- R7: `id_valid` is high for exactly the one cycle after the edge that accepts the 64th mean of a run, and `id_word` changes only on that edge.
- R8: `width_code` is sampled on the edge that accepts the first mean of a run; changes to it later in the run have no effect on that run's identifier.
- R9: Cycles with `mean_valid` low are ignored; they neither advance the run nor change the stored means, whatever `mean_data` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| width_code | input | 2 | Bits kept per difference: 0 keeps 2, 1 keeps 3, 2 or 3 keeps 4 |
| mean_valid | input | 1 | `mean_data` carries the next mean of the run |
| mean_data | input | 8 | Averaged oscillation count of one loop |
| id_valid | output | 1 | One-cycle pulse when a new identifier is on `id_word` |
| id_word | output | 252 | Packed identifier, zero-filled above the selected length |

## Verification
The bench uses the default parameters: 64 means of 8 bits, with 2 to 4 kept bits. This gives the full 126-, 189- and 252-bit layouts and the 63-difference packing boundary at the top of the word. At that size, every width code and the zero fill above each identifier length can be checked directly. Runs with wrapping differences show the modulo behaviour. So do runs whose differences differ only in their low nibbles, runs with idle gaps carrying junk data, and a width code flipped mid-run.

// File: rtl/pdib_pkg.sv
package pdib_pkg;

  // Number of top bits kept per difference for a given code,
  // clipped to the largest group the build supports.
  function automatic int unsigned keep_of(input logic [1:0] code,
                                          input int unsigned min_keep,
                                          input int unsigned max_keep);
    int unsigned k;
    k = min_keep + int'(code);
    if (k > max_keep) k = max_keep;
    return k;
  endfunction

  // Modular difference of two neighbouring means.
  function automatic logic [7:0] step_of(input logic [7:0] cur,
                                         input logic [7:0] prev);
    return cur - prev;
  endfunction

endpackage

// File: rtl/pdib_seq.sv
module pdib_seq #(
  parameter int unsigned N_LOOPS = 64,
  localparam int unsigned IDX_W = $clog2(N_LOOPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  output logic             run_start,
  output logic             run_done,
  output logic [IDX_W-1:0] slot,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_LOOPS - 1);

  logic [IDX_W-1:0] idx_q;

  assign run_start = accept && (idx_q == '0);
  assign run_done  = accept && (idx_q == LAST);
  assign slot      = idx_q - IDX_W'(1);
  assign idx       = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= '0;
    else if (run_done) idx_q <= '0;
    else if (accept)   idx_q <= idx_q + IDX_W'(1);
  end
endmodule

// File: rtl/pdib_diff.sv
module pdib_diff #(
  parameter int unsigned MEAN_W   = 8,
  parameter int unsigned KEEP_MAX = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [MEAN_W-1:0]   mean_data,
  output logic [MEAN_W-1:0]   diff,
  output logic [KEEP_MAX-1:0] top
);
  import pdib_pkg::*;

  logic [MEAN_W-1:0] prev_q;

  assign diff = step_of(mean_data, prev_q);
  assign top  = diff[MEAN_W-1 -: KEEP_MAX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_q <= '0;
    else if (accept) prev_q <= mean_data;
  end
endmodule

// File: rtl/pdib_pack.sv
module pdib_pack #(
  parameter int unsigned N_DIFF   = 63,
  parameter int unsigned MIN_KEEP = 2,
  parameter int unsigned KEEP_MAX = 4,
  localparam int unsigned ID_W = N_DIFF * KEEP_MAX
) (
  input  logic [ID_W-1:0] raw,
  input  logic [1:0]      code,
  output logic [ID_W-1:0] packed_id
);
  import pdib_pkg::*;

  logic [ID_W-1:0] variant [MIN_KEEP:KEEP_MAX];

  for (genvar g = MIN_KEEP; g <= KEEP_MAX; g++) begin : g_width
    logic [ID_W-1:0] v;
    always_comb begin
      v = '0;
      for (int k = 0; k < N_DIFF; k++) begin
        for (int b = 0; b < g; b++) begin
          v[k*g + b] = raw[k*KEEP_MAX + (KEEP_MAX - g) + b];
        end
      end
    end
    assign variant[g] = v;
  end

  always_comb begin
    packed_id = '0;
    for (int g = MIN_KEEP; g <= KEEP_MAX; g++) begin
      if (keep_of(code, MIN_KEEP, KEEP_MAX) == g) packed_id = variant[g];
    end
  end
endmodule

// File: rtl/pair_diff_id_builder.sv
module pair_diff_id_builder #(
  parameter int unsigned N_LOOPS  = 64,
  parameter int unsigned MEAN_W   = 8,
  parameter int unsigned MIN_KEEP = 2,
  parameter int unsigned KEEP_MAX = 4,
  localparam int unsigned N_DIFF = N_LOOPS - 1,
  localparam int unsigned ID_W   = N_DIFF * KEEP_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        width_code,
  input  logic              mean_valid,
  input  logic [MEAN_W-1:0] mean_data,
  output logic              id_valid,
  output logic [ID_W-1:0]   id_word
);
  localparam int unsigned IDX_W = $clog2(N_LOOPS);

  // Named internal events, observed by the bound checker.
  logic              run_start;
  logic              run_done;
  logic [IDX_W-1:0]  slot;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        run_code_q;
  logic [MEAN_W-1:0] diff;
  logic [KEEP_MAX-1:0] top;

  logic [ID_W-1:0] raw_q, raw_next, packed_id;
  logic            id_valid_q;
  logic [ID_W-1:0] id_word_q;

  pdib_seq #(.N_LOOPS(N_LOOPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(mean_valid),
    .run_start(run_start), .run_done(run_done), .slot(slot), .idx(idx)
  );

  pdib_diff #(.MEAN_W(MEAN_W), .KEEP_MAX(KEEP_MAX)) u_diff (
    .clk(clk), .rst_n(rst_n), .accept(mean_valid),
    .mean_data(mean_data), .diff(diff), .top(top)
  );

  always_comb begin
    raw_next = raw_q;
    if (mean_valid && !run_start) begin
      for (int k = 0; k < N_DIFF; k++) begin
        if (slot == IDX_W'(k)) raw_next[k*KEEP_MAX +: KEEP_MAX] = top;
      end
    end
  end

  pdib_pack #(.N_DIFF(N_DIFF), .MIN_KEEP(MIN_KEEP), .KEEP_MAX(KEEP_MAX)) u_pack (
    .raw(raw_next), .code(run_code_q), .packed_id(packed_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q      <= '0;
      run_code_q <= '0;
      id_valid_q <= 1'b0;
      id_word_q  <= '0;
    end else begin
      id_valid_q <= run_done;
      if (mean_valid) raw_q <= raw_next;
      if (run_start)  run_code_q <= width_code;
      if (run_done)   id_word_q <= packed_id;
    end
  end

  assign id_valid = id_valid_q;
  assign id_word  = id_word_q;
endmodule

// File: rtl/pdib_checker.sv
module pdib_checker #(
  parameter int unsigned N_LOOPS  = 64,
  parameter int unsigned MIN_KEEP = 2,
  parameter int unsigned KEEP_MAX = 4,
  localparam int unsigned N_DIFF = N_LOOPS - 1,
  localparam int unsigned ID_W   = N_DIFF * KEEP_MAX,
  localparam int unsigned IDX_W  = $clog2(N_LOOPS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mean_valid,
  input logic             run_start,
  input logic             run_done,
  input logic [1:0]       run_code_q,
  input logic [IDX_W-1:0] idx,
  input logic             id_valid,
  input logic [ID_W-1:0]  id_word
);
  import pdib_pkg::*;

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |=> id_valid);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);

  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_done |=> $stable(id_word));

  p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_start |=> $stable(run_code_q));

  p_idle_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mean_valid |=> $stable(idx));

  p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && keep_of(run_code_q, MIN_KEEP, KEEP_MAX) == MIN_KEEP)
      |-> ((id_word >> (N_DIFF * MIN_KEEP)) == '0));
endmodule

bind pair_diff_id_builder pdib_checker #(
  .N_LOOPS(N_LOOPS), .MIN_KEEP(MIN_KEEP), .KEEP_MAX(KEEP_MAX)
) u_pdib_checker (
  .clk(clk), .rst_n(rst_n), .mean_valid(mean_valid),
  .run_start(run_start), .run_done(run_done), .run_code_q(run_code_q),
  .idx(idx), .id_valid(id_valid), .id_word(id_word)
);

// File: tb/test_pair_diff_id_builder.sv
module test_pair_diff_id_builder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   width_code = '0;
  logic         mean_valid = 1'b0;
  logic [7:0]   mean_data = '0;
  logic         id_valid;
  logic [251:0] id_word;

  int checks = 0;
  int fails  = 0;
  logic [7:0]   means [64];
  logic [251:0] last_id;

  pair_diff_id_builder i_pair_diff_id_builder (
    .clk(clk), .rst_n(rst_n), .width_code(width_code),
    .mean_valid(mean_valid), .mean_data(mean_data),
    .id_valid(id_valid), .id_word(id_word)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [251:0] act, input logic [251:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: build from the top difference downward, shifting left.
  function automatic logic [251:0] model(input logic [1:0] code);
    int w;
    logic [251:0] acc;
    logic [7:0] d;
    w = (code == 2'd0) ? 2 : (code == 2'd1) ? 3 : 4;
    acc = '0;
    for (int k = 62; k >= 0; k--) begin
      d = means[k+1] - means[k];
      acc = (acc << w) | 252'(d >> (8 - w));
    end
    return acc;
  endfunction

  task automatic from_diffs(input logic [7:0] start, input logic [7:0] d [63]);
    means[0] = start;
    for (int k = 0; k < 63; k++) means[k+1] = means[k] + d[k];
  endtask

  // Drives one run of 64 means and checks the result pulse and hold (R7).
  task automatic run_and_check(input string req, input logic [1:0] code,
                               input int gap, input bit flip);
    logic [251:0] exp;
    exp = model(code);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      mean_valid = 1'b1;
      mean_data  = means[k];
      width_code = (k == 0 || !flip) ? code : ~code;
      if (k == 63) check(id_valid == 1'b0, {req, " R7 no early valid"}, 252'(id_valid), 252'd0);
      for (int g = 0; g < gap && k < 63; g++) begin
        @(negedge clk);
        mean_valid = 1'b0;
        mean_data  = 8'hA5 ^ 8'(g);
      end
    end
    @(negedge clk);
    mean_valid = 1'b0;
    check(id_valid == 1'b1, {req, " R7 valid pulse"}, 252'(id_valid), 252'd1);
    check(id_word == exp, req, id_word, exp);
    last_id = id_word;
    @(negedge clk);
    check(id_valid == 1'b0, {req, " R7 pulse one cycle"}, 252'(id_valid), 252'd0);
    check(id_word == last_id, {req, " R7 word held"}, id_word, last_id);
  endtask

  task automatic t_reset();
    check(id_valid == 1'b0, "R1 valid at reset", 252'(id_valid), 252'd0);
    check(id_word == '0, "R1 word at reset", id_word, '0);
  endtask

  task automatic t_two_bits();
    for (int k = 0; k < 64; k++) means[k] = 8'((k * k * 13 + 7));
    run_and_check("R3 two bits", 2'd0, 0, 1'b0);
    check((last_id >> 126) == '0, "R3 zero fill", last_id >> 126, '0);
  endtask

  task automatic t_three_bits();
    for (int k = 0; k < 64; k++) means[k] = 8'((k * 37 + k * k * 5));
    run_and_check("R4 three bits", 2'd1, 0, 1'b0);
    check((last_id >> 189) == '0, "R4 zero fill", last_id >> 189, '0);
  endtask

  task automatic t_four_bits();
    for (int k = 0; k < 64; k++) means[k] = 8'((k * 91 + 3));
    run_and_check("R5 four bits code 2", 2'd2, 0, 1'b0);
    for (int k = 0; k < 64; k++) means[k] = 8'((k * k * 29 + k));
    run_and_check("R5 four bits code 3", 2'd3, 0, 1'b0);
  endtask

  task automatic t_wrap();
    logic [7:0] d [63];
    for (int k = 0; k < 63; k++) d[k] = 8'hF5 - 8'(k);
    from_diffs(8'h10, d);
    run_and_check("R2 wrapping differences", 2'd2, 0, 1'b0);
    check(last_id[3:0] == 4'hF, "R2 first group 0xF", 252'(last_id[3:0]), 252'hF);
  endtask

  task automatic t_low_bits();
    logic [7:0] d [63];
    logic [251:0] first;
    for (int k = 0; k < 63; k++) d[k] = {4'(k * 7), 4'h0};
    from_diffs(8'h33, d);
    run_and_check("R6 low nibble zero", 2'd2, 0, 1'b0);
    first = last_id;
    for (int k = 0; k < 63; k++) d[k] = {4'(k * 7), 4'(k * 5 + 9)};
    from_diffs(8'h33, d);
    run_and_check("R6 low nibble varied", 2'd2, 0, 1'b0);
    check(last_id == first, "R6 low bits ignored", last_id, first);
  endtask

  task automatic t_gaps();
    for (int k = 0; k < 64; k++) means[k] = 8'((k * 53 + 200));
    run_and_check("R9 idle gaps", 2'd1, 2, 1'b0);
  endtask

  task automatic t_cfg_mid_run();
    for (int k = 0; k < 64; k++) means[k] = 8'((k * k * 3 + 17 * k));
    run_and_check("R8 code flipped mid-run", 2'd0, 0, 1'b1);
    check((last_id >> 126) == '0, "R8 short length kept", last_id >> 126, '0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_two_bits();
    t_three_bits();
    t_four_bits();
    t_wrap();
    t_low_bits();
    t_gaps();
    t_cfg_mid_run();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule